// File: doc/BRIEF.md
# 8-bit ALU with Two-Cycle Multiplier

This block is the arithmetic and logic unit of a small RISC core. Each accepted request brings two operands, an operation code and the current status flags. One registered result comes back per request: an 8-bit value, or a 16-bit product for the multiply family, together with the status flags after the operation. Fetch, decode, the register file and branching sit outside the block. The core drives the operation code directly as a select value.

The status flags are carry C, zero Z, negative N, two's complement overflow V, sign S, half carry H and the user bit T. Every operation has its own update mask. Flags outside the mask are passed from `flags_in` to `flags_out` unchanged. Subtract-with-carry and compare-with-carry can only keep or clear Z, so a compare over several bytes gives the right result across the whole word. Multiplies use a register stage and take two cycles. All other operations take one cycle.

Top module: `alu_core`

## Requirements
- R1: Flag vector layout: bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H, bit 6 T. Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 CMPC, 6 AND, 7 OR, 8 XOR, 9 COM, 10 NEG, 11 SHL, 12 SHR, 13 ROL, 14 ROR, 15 ASR, 16 SWAP, 17 MULUU, 18 MULSS, 19 MULSU, 20 FMULUU, 21 FMULSS, 22 FMULSU. For every operation that updates N or V, S equals N XOR V of the new flags.
- R2: ADD and ADC return a+b (ADC also adds C). They set C to the carry out of bit 7, H to the carry out of bit 3, V to signed overflow, N to bit 7 and Z when the result is zero.
- R3: SUB, SBC, CMP and CMPC compute a−b (SBC and CMPC also subtract C). They set C to the borrow out of bit 7, H to the borrow out of bit 3, V to signed overflow and N to bit 7. For SUB and CMP, Z is set when the result is zero. For SBC and CMPC, the new Z is (result==0) AND the incoming Z.
- R4: CMP and CMPC drive `wr_en` low with their result. Every other operation drives it high.
- R5: AND, OR and XOR update Z, N and V with V cleared. C and H keep their incoming values.
- R6: COM returns 0xFF−a and sets C to 1 and V to 0. NEG returns 0x00−a and updates C, Z, N, V and H like a subtraction from zero. Neither uses operand b.
- R7: SHL and SHR shift in 0. ROL and ROR shift in the incoming C. ASR keeps bit 7. C takes the bit shifted out, V = N XOR C, and Z and N follow the result. H is unchanged.
- R8: SWAP exchanges bits 7..4 with bits 3..0 and leaves every flag unchanged.
- R9: MULUU, MULSS and MULSU multiply unsigned×unsigned, signed×signed and signed a × unsigned b. The 16-bit product goes out on `result_hi`:`result`. Only C and Z are updated: C is product bit 15 and Z is set when the product is zero.
- R10: FMULUU, FMULSS and FMULSU return the matching product shifted left by one bit. C is bit 15 before the shift, and Z follows the shifted value.
- R11: `done` is high for one cycle, one cycle after a non-multiply request is accepted and two cycles after a multiply request is accepted. `result_hi` is 0 for non-multiply operations.
- R12: A request made in the cycle after an accepted multiply request is ignored. It produces no `done` pulse and does not disturb the product.
- R13: While reset is held, all outputs are zero.
- R14: T is never changed by any operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled at the rising edge |
| op_sel | input | 5 | Operation code (R1) |
| a | input | DATA_W | First operand (destination side) |
| b | input | DATA_W | Second operand |
| flags_in | input | 7 | Incoming status flags (R1 layout) |
| result | output | DATA_W | Result, or low half of a product |
| result_hi | output | DATA_W | High half of a product, 0 otherwise |
| flags_out | output | 7 | Updated status flags |
| done | output | 1 | One-cycle pulse marking valid outputs |
| wr_en | output | 1 | Result should be written back |

## Verification
The bench builds the block with its default DATA_W of 8, so operand values such as 0x7F, 0x80 and 0xFF can be driven directly. At that width every sign and carry boundary is one chosen vector. This includes signed overflow in both directions, the carry out of the low nibble, and the most negative operand under negation and signed multiply. It also puts the fractional products whose carry comes from the bit lost in the shift within reach, along with the chained zero flag of carried subtraction. Each response is checked against a model built from the requirements.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
// Shared types for the ALU: the operation code, the flag vector layout, and
// the per-operation flag update mask. Assumes a 7-bit flag vector.
package alu_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 7;
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;
    localparam int FT = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC,
        OP_AND, OP_OR, OP_XOR, OP_COM, OP_NEG,
        OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_ASR, OP_SWAP,
        OP_MULUU, OP_MULSS, OP_MULSU, OP_FMULUU, OP_FMULSS, OP_FMULSU
    } alu_op_e;

    // True for the six multiply codes.
    function automatic logic is_mul(input alu_op_e op);
        return op inside {OP_MULUU, OP_MULSS, OP_MULSU,
                          OP_FMULUU, OP_FMULSS, OP_FMULSU};
    endfunction

    // Flags an operation is allowed to write; the rest pass through.
    function automatic logic [FLAG_W-1:0] upd_mask(input alu_op_e op);
        logic [FLAG_W-1:0] m;
        m = '0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG: begin
                m[FC] = 1'b1; m[FZ] = 1'b1; m[FN] = 1'b1;
                m[FV] = 1'b1; m[FS] = 1'b1; m[FH] = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                m[FZ] = 1'b1; m[FN] = 1'b1; m[FV] = 1'b1; m[FS] = 1'b1;
            end
            OP_COM, OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_ASR: begin
                m[FC] = 1'b1; m[FZ] = 1'b1; m[FN] = 1'b1;
                m[FV] = 1'b1; m[FS] = 1'b1;
            end
            OP_MULUU, OP_MULSS, OP_MULSU, OP_FMULUU, OP_FMULSS, OP_FMULSU: begin
                m[FC] = 1'b1; m[FZ] = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alu_arith.sv
`timescale 1ns/1ps
// Add/subtract datapath shared by ADD, ADC, SUB, SBC, CMP, CMPC and NEG.
// Produces the result and a candidate flag vector; the caller applies the
// update mask. Assumes DATA_W is even so the half carry sits at DATA_W/2.
module alu_arith
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              c_in,
    input  logic              z_in,
    output logic [DATA_W-1:0] res,
    output logic [FLAG_W-1:0] fl
);
    localparam int NIB = DATA_W / 2;

    logic              use_sub;
    logic              cin;
    logic [DATA_W-1:0] x;
    logic [DATA_W-1:0] y;
    logic [DATA_W:0]   full;
    logic              ovf;
    logic              zero;

    // One adder/subtractor; NEG is 0 minus the operand.
    always_comb begin
        use_sub = op inside {OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG};
        cin     = c_in & (op inside {OP_ADC, OP_SBC, OP_CMPC});
        x       = (op == OP_NEG) ? '0 : a;
        y       = (op == OP_NEG) ? a  : b;
        if (use_sub)
            full = {1'b0, x} - {1'b0, y} - {{DATA_W{1'b0}}, cin};
        else
            full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        res  = full[DATA_W-1:0];
        ovf  = use_sub ? ((x[DATA_W-1] != y[DATA_W-1]) && (res[DATA_W-1] != x[DATA_W-1]))
                       : ((x[DATA_W-1] == y[DATA_W-1]) && (res[DATA_W-1] != x[DATA_W-1]));
        zero = (res == '0) && (!(op inside {OP_SBC, OP_CMPC}) || z_in);
        fl      = '0;
        fl[FC]  = full[DATA_W];
        fl[FZ]  = zero;
        fl[FN]  = res[DATA_W-1];
        fl[FV]  = ovf;
        fl[FS]  = res[DATA_W-1] ^ ovf;
        fl[FH]  = x[NIB] ^ y[NIB] ^ res[NIB];
    end
endmodule

// File: rtl/alu_bitops.sv
`timescale 1ns/1ps
// Logic, complement, shift/rotate and nibble swap datapath.
// Produces the result and a candidate flag vector; H is never produced here.
module alu_bitops
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic [FLAG_W-1:0] fl
);
    localparam int NIB = DATA_W / 2;

    logic cy;
    logic ovf;

    // Select the bitwise result and the bit shifted out.
    always_comb begin
        cy = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  begin res = ~a; cy = 1'b1; end
            OP_SHL:  begin res = {a[DATA_W-2:0], 1'b0};        cy = a[DATA_W-1]; end
            OP_ROL:  begin res = {a[DATA_W-2:0], c_in};        cy = a[DATA_W-1]; end
            OP_SHR:  begin res = {1'b0, a[DATA_W-1:1]};        cy = a[0]; end
            OP_ROR:  begin res = {c_in, a[DATA_W-1:1]};        cy = a[0]; end
            OP_ASR:  begin res = {a[DATA_W-1], a[DATA_W-1:1]}; cy = a[0]; end
            OP_SWAP: res = {a[NIB-1:0], a[DATA_W-1:NIB]};
            default: res = a;
        endcase
        ovf    = (op inside {OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_ASR}) ? (res[DATA_W-1] ^ cy) : 1'b0;
        fl     = '0;
        fl[FC] = cy;
        fl[FZ] = (res == '0);
        fl[FN] = res[DATA_W-1];
        fl[FV] = ovf;
        fl[FS] = res[DATA_W-1] ^ ovf;
    end
endmodule

// File: rtl/alu_mul.sv
`timescale 1ns/1ps
// Multiplier stage: captures operands, variant and flags on load, then
// presents the product one cycle later while busy is high. Signedness is
// handled by sign-extending to the product width; fractional forms shift
// left by one and report carry from the unshifted bit 2*DATA_W-1.
module alu_mul
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [FLAG_W-1:0]   flags_in,
    output logic                busy,
    output alu_op_e             op_q,
    output logic [FLAG_W-1:0]   flags_q,
    output logic [2*DATA_W-1:0] prod,
    output logic                carry
);
    localparam int PW = 2 * DATA_W;

    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic              sa;
    logic              sb;
    logic [PW-1:0]     ax;
    logic [PW-1:0]     bx;
    logic [PW-1:0]     raw;

    // Operand capture register for the two-cycle multiply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            op_q    <= OP_MULUU;
            flags_q <= '0;
            a_q     <= '0;
            b_q     <= '0;
        end else begin
            busy <= load;
            if (load) begin
                op_q    <= op;
                flags_q <= flags_in;
                a_q     <= a;
                b_q     <= b;
            end
        end
    end

    // Sign-extend per variant, multiply, and apply the fractional shift.
    always_comb begin
        sa    = op_q inside {OP_MULSS, OP_MULSU, OP_FMULSS, OP_FMULSU};
        sb    = op_q inside {OP_MULSS, OP_FMULSS};
        ax    = {{DATA_W{sa & a_q[DATA_W-1]}}, a_q};
        bx    = {{DATA_W{sb & b_q[DATA_W-1]}}, b_q};
        raw   = ax * bx;
        carry = raw[PW-1];
        prod  = (op_q inside {OP_FMULUU, OP_FMULSS, OP_FMULSU}) ? {raw[PW-2:0], 1'b0} : raw;
    end
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
// ALU top: routes a request to the add/subtract path, the bitwise path or
// the multiplier, merges flags through the per-operation mask and registers
// the outputs. Assumes the caller holds no request in the cycle after a
// multiply is accepted; such a request is dropped.
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] result_hi,
    output logic [FLAG_W-1:0] flags_out,
    output logic              done,
    output logic              wr_en
);
    localparam int PW = 2 * DATA_W;

    alu_op_e           op;
    logic              mul_busy;
    logic              accept;
    logic              op_mul;
    logic [DATA_W-1:0] ar_res, bo_res, s_res;
    logic [FLAG_W-1:0] ar_fl, bo_fl, s_cand, s_mask, s_flags;
    alu_op_e           mul_op;
    logic [FLAG_W-1:0] mul_fin, m_cand, m_mask, m_flags;
    logic [PW-1:0]     mul_prod;
    logic              mul_carry;

    assign op     = alu_op_e'(op_sel);
    assign op_mul = is_mul(op);
    assign accept = start & ~mul_busy;

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .op(op), .a(a), .b(b), .c_in(flags_in[FC]), .z_in(flags_in[FZ]),
        .res(ar_res), .fl(ar_fl)
    );

    alu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op(op), .a(a), .b(b), .c_in(flags_in[FC]),
        .res(bo_res), .fl(bo_fl)
    );

    alu_mul #(.DATA_W(DATA_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(accept & op_mul), .op(op),
        .a(a), .b(b), .flags_in(flags_in), .busy(mul_busy), .op_q(mul_op),
        .flags_q(mul_fin), .prod(mul_prod), .carry(mul_carry)
    );

    // Pick the single-cycle path and merge its flags through the mask.
    always_comb begin
        if (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG}) begin
            s_res  = ar_res;
            s_cand = ar_fl;
        end else begin
            s_res  = bo_res;
            s_cand = bo_fl;
        end
        s_mask  = upd_mask(op);
        s_flags = (s_mask & s_cand) | (~s_mask & flags_in);
    end

    // Build multiply flags from the registered product.
    always_comb begin
        m_cand     = '0;
        m_cand[FC] = mul_carry;
        m_cand[FZ] = (mul_prod == '0);
        m_mask     = upd_mask(mul_op);
        m_flags    = (m_mask & m_cand) | (~m_mask & mul_fin);
    end

    // Output register: multiply completion takes precedence over new work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            result_hi <= '0;
            flags_out <= '0;
            done      <= 1'b0;
            wr_en     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (mul_busy) begin
                result    <= mul_prod[DATA_W-1:0];
                result_hi <= mul_prod[PW-1:DATA_W];
                flags_out <= m_flags;
                wr_en     <= 1'b1;
                done      <= 1'b1;
            end else if (accept && !op_mul) begin
                result    <= s_res;
                result_hi <= '0;
                flags_out <= s_flags;
                wr_en     <= !(op inside {OP_CMP, OP_CMPC});
                done      <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/alu_core_chk.sv
`timescale 1ns/1ps
// Protocol and flag checker for alu_core, bound to every instance.
// Keeps its own record of accepted requests to relate outputs to inputs.
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OP_W-1:0]   op_sel,
    input logic [FLAG_W-1:0] flags_in,
    input logic [FLAG_W-1:0] flags_out,
    input logic [DATA_W-1:0] result_hi,
    input logic              done,
    input logic              wr_en
);
    logic            pend, acc_s_q, acc_m_q, acc_m_qq;
    logic [OP_W-1:0] op_q;
    logic [FLAG_W-1:0] fin_q;
    logic            acc, req_mul;

    assign req_mul = op_sel inside {[5'd17:5'd22]};
    assign acc     = start && !pend;

    // Track accepted requests and the operation and flags they carried.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; acc_s_q <= 1'b0; acc_m_q <= 1'b0; acc_m_qq <= 1'b0;
            op_q <= '0; fin_q <= '0;
        end else begin
            pend     <= acc && req_mul;
            acc_s_q  <= acc && !req_mul;
            acc_m_q  <= acc && req_mul;
            acc_m_qq <= acc_m_q;
            if (acc) begin
                op_q  <= op_sel;
                fin_q <= flags_in;
            end
        end
    end

    assert_single_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_s_q |-> (done && result_hi == '0));
    assert_mul_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_m_q |-> !done);
    assert_mul_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_m_qq |-> done);
    assert_no_stray_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_s_q || acc_m_qq));
    assert_compare_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == 5'd4 || op_q == 5'd5)) |-> !wr_en);
    assert_t_kept_R14: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FT] == fin_q[FT]));
    assert_swap_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 5'd16) |-> (flags_out == fin_q));
    assert_sign_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q <= 5'd15) |-> (flags_out[FS] == (flags_out[FN] ^ flags_out[FV])));
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .flags_in(flags_in), .flags_out(flags_out), .result_hi(result_hi),
    .done(done), .wr_en(wr_en)
);

// File: tb/alu_core_test.sv
`timescale 1ns/1ps
module alu_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] a = '0;
    logic [7:0] b = '0;
    logic [6:0] flags_in = '0;
    logic [7:0] result, result_hi;
    logic [6:0] flags_out;
    logic       done, wr_en;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    alu_core #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .a(a), .b(b),
        .flags_in(flags_in), .result(result), .result_hi(result_hi),
        .flags_out(flags_out), .done(done), .wr_en(wr_en)
    );

    // Expected {wr_en, result_hi, result, flags} from the requirements.
    function automatic logic [23:0] model(input int op, input int x, input int y, input logic [6:0] fi);
        logic [6:0] f = fi;
        logic       c = fi[0];
        logic       wr = 1'b1;
        int r = 0, hi = 0, t, cin, sx, sy, sv, u, v, p;
        sx = (x > 127) ? x - 256 : x;
        sy = (y > 127) ? y - 256 : y;
        case (op)
            0, 1: begin
                cin = (op == 1) ? int'(c) : 0;
                t = x + y + cin; r = t & 255;
                sv = sx + sy + cin;
                f[0] = t > 255; f[5] = ((x & 15) + (y & 15) + cin) > 15;
                f[3] = (sv > 127) || (sv < -128); f[1] = (r == 0);
            end
            2, 3, 4, 5, 10: begin
                u = x; v = y;
                if (op == 10) begin u = 0; v = x; sy = sx; sx = 0; end
                cin = (op == 3 || op == 5) ? int'(c) : 0;
                t = u - v - cin; r = t & 255;
                sv = sx - sy - cin;
                f[0] = t < 0; f[5] = ((u & 15) - (v & 15) - cin) < 0;
                f[3] = (sv > 127) || (sv < -128);
                f[1] = (r == 0) && ((op == 3 || op == 5) ? fi[1] : 1'b1);
                wr = !(op == 4 || op == 5);
            end
            6, 7, 8, 9: begin
                r = (op == 6) ? (x & y) : (op == 7) ? (x | y) : (op == 8) ? (x ^ y) : (255 - x);
                if (op == 9) f[0] = 1'b1;
                f[3] = 1'b0; f[1] = (r == 0);
            end
            11, 12, 13, 14, 15: begin
                case (op)
                    11: begin r = (x << 1) & 255;                f[0] = x[7]; end
                    13: begin r = ((x << 1) & 255) | int'(c);     f[0] = x[7]; end
                    12: begin r = x >> 1;                         f[0] = x[0]; end
                    14: begin r = (x >> 1) | (int'(c) << 7);      f[0] = x[0]; end
                    default: begin r = (x >> 1) | (x & 128);      f[0] = x[0]; end
                endcase
                f[1] = (r == 0); f[3] = (r > 127) ^ f[0];
            end
            16: r = ((x & 15) << 4) | (x >> 4);
            default: begin
                u = (op == 18 || op == 19 || op == 21 || op == 22) ? sx : x;
                v = (op == 18 || op == 21) ? sy : y;
                p = (u * v) & 65535;
                f[0] = (p >> 15) & 1;
                if (op >= 20) p = (p << 1) & 65535;
                f[1] = (p == 0);
                r = p & 255; hi = p >> 8;
            end
        endcase
        if (op <= 15) begin
            f[2] = r > 127;
            f[4] = f[2] ^ f[3];
        end
        return {wr, hi[7:0], r[7:0], f};
    endfunction

    task automatic check(input string req, input logic [24:0] got, input logic [24:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Issue one request, wait the documented latency, compare every output.
    task automatic apply(input string req, input int op, input int x, input int y, input logic [6:0] fi);
        @(negedge clk);
        start = 1'b1; op_sel = op[4:0]; a = x[7:0]; b = y[7:0]; flags_in = fi;
        @(negedge clk);
        start = 1'b0;
        if (op >= 17) begin
            check({req, " R11 gap"}, {24'd0, done}, 25'd0);
            @(negedge clk);
        end
        check(req, {done, wr_en, result_hi, result, flags_out}, {1'b1, model(op, x, y, fi)});
    endtask

    task automatic test_reset();
        check("R13 reset", {done, wr_en, result_hi, result, flags_out}, 25'd0);
    endtask

    task automatic test_add();
        apply("R2 R1 add overflow", 0, 8'h7F, 8'h01, 7'h40);
        apply("R2 add wrap to zero", 0, 8'hFF, 8'h01, 7'h00);
        apply("R2 adc carry in", 1, 8'h0F, 8'h00, 7'h41);
    endtask

    task automatic test_sub();
        apply("R3 sub half borrow", 2, 8'h10, 8'h01, 7'h40);
        apply("R3 sub borrow", 2, 8'h00, 8'h01, 7'h00);
        apply("R3 sbc zero kept clear", 3, 8'h05, 8'h05, 7'h00);
        apply("R3 sbc zero chained", 3, 8'h05, 8'h04, 7'h03);
        apply("R3 sbc zero cleared", 3, 8'h06, 8'h04, 7'h03);
    endtask

    task automatic test_compare();
        apply("R4 cmp equal", 4, 8'h33, 8'h33, 7'h40);
        apply("R4 R3 cmpc overflow", 5, 8'h80, 8'h01, 7'h02);
    endtask

    task automatic test_logic();
        apply("R5 and keeps C H", 6, 8'hF0, 8'h3C, 7'h29);
        apply("R5 or negative", 7, 8'h80, 8'h00, 7'h08);
        apply("R5 xor zero", 8, 8'h55, 8'h55, 7'h21);
    endtask

    task automatic test_unary();
        apply("R6 com", 9, 8'h0F, 8'hAA, 7'h00);
        apply("R6 neg most negative", 10, 8'h80, 8'h11, 7'h40);
        apply("R6 neg zero", 10, 8'h00, 8'h22, 7'h01);
    endtask

    task automatic test_shift();
        apply("R7 shl", 11, 8'h81, 0, 7'h20);
        apply("R7 shr to zero", 12, 8'h01, 0, 7'h00);
        apply("R7 rol carry in", 13, 8'h80, 0, 7'h01);
        apply("R7 ror carry in", 14, 8'h01, 0, 7'h01);
        apply("R7 asr keeps sign", 15, 8'h81, 0, 7'h00);
    endtask

    task automatic test_swap();
        apply("R8 swap all flags set", 16, 8'hA5, 0, 7'h7F);
        apply("R8 swap no flags", 16, 8'h3C, 0, 7'h00);
    endtask

    task automatic test_mul();
        apply("R9 muluu max", 17, 8'hFF, 8'hFF, 7'h7C);
        apply("R9 mulss minus one", 18, 8'hFF, 8'h01, 7'h40);
        apply("R9 mulsu mixed", 19, 8'h80, 8'hFF, 7'h00);
        apply("R9 muluu zero", 17, 8'h00, 8'h05, 7'h3C);
    endtask

    task automatic test_frac();
        apply("R10 fmuluu", 20, 8'h80, 8'h80, 7'h00);
        apply("R10 fmulss", 21, 8'h80, 8'h80, 7'h40);
        apply("R10 fmulsu carry", 22, 8'hC0, 8'h80, 7'h00);
        apply("R10 fmuluu max", 20, 8'hFF, 8'hFF, 7'h01);
    endtask

    // A request right behind a multiply must be dropped.
    task automatic test_ignore();
        @(negedge clk);
        start = 1'b1; op_sel = 5'd17; a = 8'h10; b = 8'h10; flags_in = 7'h40;
        @(negedge clk);
        op_sel = 5'd0; a = 8'h01; b = 8'h01; flags_in = 7'h00;
        @(negedge clk);
        start = 1'b0;
        check("R12 product survives", {done, wr_en, result_hi, result, flags_out},
              {1'b1, model(17, 8'h10, 8'h10, 7'h40)});
        @(negedge clk);
        check("R12 no extra done", {24'd0, done}, 25'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_add();
        test_sub();
        test_compare();
        test_logic();
        test_unary();
        test_shift();
        test_swap();
        test_mul();
        test_frac();
        test_ignore();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule